// File: doc/BRIEF.md
# Conditional Trap Decision and Exception Entry Stage

This is a purely combinational execute stage for the trap instructions of a 64-bit processor. It compares two operands five ways: signed less and greater, unsigned less and greater, and equality. A 5-bit condition mask picks which of those outcomes cause a trap. A trap-type vector from the decoder can also force a trap with no compare at all.

When a trap is taken, the stage builds the exception-entry state in one pass. This state is the new machine status word, the saved return address, the saved status word with its trap-reason bits, and the fetch address of the handler. Each of the four results has its own valid flag.

The decoder supplies the mask as instruction bits 25..21, so mask bit 0 is instruction bit 21. A 32-bit-mode flag limits the compare to the low words of the operands. All status-word bit positions are module parameters, with defaults in a shared package.

Top module: `trap_entry_stage`

## Requirements
- R1: Mask bit k (input `cond_mask_i[k]`, fed from instruction bit 21+k) enables compare outcome k. The outcome positions are: 0 = unsigned greater, 1 = unsigned less, 2 = equal, 3 = signed greater, 4 = signed less.
- R2: With `is32_i` = 1, only the low 32 bits of each operand take part. Signed compares use the sign-extended low words and unsigned compares use the zero-extended low words. With `is32_i` = 0, all 64 bits are compared.
- R3: A trap is taken when any bit of `trap_type_i` is 1, or when any compare outcome is 1 while its mask bit is 1.
- R4: On a trap, `msr_o` equals `msr_i` with these bits cleared: instruction relocate (5), data relocate (4), FP exception modes (11, 8), external enable (15), recoverable (1), TM (32), vector (25), VSX (23), problem state (14), FP available (13), performance mark (2), trace enable field (10:9) and the undefined bit (6). The 64-bit mode bit (63) and the little-endian bit (0) are set.
- R5: On a trap, the 2-bit transaction-state field (bits 34:33) becomes 01 when its old value is 10. Any other value is kept.
- R6: On a trap, `srr0_o` equals `cia_i`.
- R7: On a trap, `srr1_o` equals `msr_i` with bits 30..27 cleared, except for the reason bits of R8.
- R8: On a trap, `srr1_o` takes these reason bits:
  - bit 17 is 1 exactly when `trap_type_i` is all zero;
  - bit 18 copies `trap_type_i[1]`;
  - bit 20 copies `trap_type_i[0]`;
  - bit 16 copies `trap_type_i[3]`;
  - bit 19 copies `trap_type_i[4]`;
  - bit 21 is 0.
  
  `trap_type_i[2]` sets no reason bit.
- R9: On a trap, `nia_o` equals `vec_idx_i` shifted left by 4.
- R10: On a trap, all four valid flags are 1. With no trap, all four valid flags are 0 and all four data outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_i | input | 64 | First compare operand |
| b_i | input | 64 | Second compare operand |
| cond_mask_i | input | 5 | Condition mask from instruction bits 25..21 |
| is32_i | input | 1 | Compare low words only |
| trap_type_i | input | 5 | Decoder-forced trap types |
| msr_i | input | 64 | Current machine status word |
| cia_i | input | 64 | Address of the current instruction |
| vec_idx_i | input | 12 | Handler vector index |
| msr_o | output | 64 | New machine status word |
| msr_vld_o | output | 1 | `msr_o` valid |
| srr0_o | output | 64 | Saved return address |
| srr0_vld_o | output | 1 | `srr0_o` valid |
| srr1_o | output | 64 | Saved status word |
| srr1_vld_o | output | 1 | `srr1_o` valid |
| nia_o | output | 64 | Next fetch address |
| nia_vld_o | output | 1 | `nia_o` valid |

## Verification
The hardest cases are operand pairs where the signed and unsigned orders disagree. The most awkward of these are in 32-bit mode, where the low words sit on the sign boundary but the discarded high words would give the opposite answer. Uniformly random operands almost never produce equality or those boundaries. The stimulus therefore draws from several operand classes: equal pairs, low-word-equal pairs with different high words, sign-boundary values and small integers. It also uses single-bit masks, so each compare outcome is observed in isolation. The transaction-state rewrite and the reason-bit mapping each get directed vectors.

// File: rtl/trap_pkg.sv
package trap_pkg;
  localparam int XLEN   = 64;
  localparam int TT_W   = 5;
  localparam int VIDX_W = 12;

  // status word bit positions (bit 0 = least significant)
  localparam int P_SF   = 63;
  localparam int P_TM   = 32;
  localparam int P_TS_L = 33;
  localparam int P_VEC  = 25;
  localparam int P_VSX  = 23;
  localparam int P_EE   = 15;
  localparam int P_PR   = 14;
  localparam int P_FP   = 13;
  localparam int P_FE0  = 11;
  localparam int P_TE_L = 9;
  localparam int P_FE1  = 8;
  localparam int P_UND  = 6;
  localparam int P_IR   = 5;
  localparam int P_DR   = 4;
  localparam int P_PMM  = 2;
  localparam int P_RI   = 1;
  localparam int P_LE   = 0;

  // saved status reason bits
  localparam int S_ADR  = 16;
  localparam int S_TRAP = 17;
  localparam int S_PRIV = 18;
  localparam int S_ILL  = 19;
  localparam int S_FP   = 20;
  localparam int S_TMB  = 21;
  localparam int S_CLR_L = 27;
  localparam int S_CLR_H = 30;

  // compare outcome order
  typedef enum logic [2:0] {
    CMP_GTU = 3'd0, CMP_LTU = 3'd1, CMP_EQ = 3'd2, CMP_GTS = 3'd3, CMP_LTS = 3'd4
  } cmp_pos_e;
endpackage

// File: rtl/trap_cmp.sv
module trap_cmp #(
  parameter int W = 64
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         is32_i,
  output logic [4:0]   res_o
);
  localparam int H = W / 2;

  logic [W-1:0] a_s, b_s, a_u, b_u;
  logic lt_s, gt_s, lt_u, gt_u, eq;

  always_comb begin
    if (is32_i) begin
      a_s = {{H{a_i[H-1]}}, a_i[H-1:0]};
      b_s = {{H{b_i[H-1]}}, b_i[H-1:0]};
      a_u = {{H{1'b0}}, a_i[H-1:0]};
      b_u = {{H{1'b0}}, b_i[H-1:0]};
    end else begin
      a_s = a_i;
      b_s = b_i;
      a_u = a_i;
      b_u = b_i;
    end
    lt_s = $signed(a_s) < $signed(b_s);
    gt_s = $signed(a_s) > $signed(b_s);
    lt_u = a_u < b_u;
    gt_u = a_u > b_u;
    eq   = a_u == b_u;
    res_o = '0;
    res_o[trap_pkg::CMP_GTU] = gt_u;
    res_o[trap_pkg::CMP_LTU] = lt_u;
    res_o[trap_pkg::CMP_EQ]  = eq;
    res_o[trap_pkg::CMP_GTS] = gt_s;
    res_o[trap_pkg::CMP_LTS] = lt_s;
  end

  // R2: unsigned order of the selected words is a strict trichotomy
  always_comb begin
    p_cmp_tri_r2: assert ($countones({lt_u, gt_u, eq}) == 1)
      else $error("R2 unsigned outcome not exclusive");
  end
endmodule

// File: rtl/trap_msr_gen.sv
module trap_msr_gen #(
  parameter int W     = 64,
  parameter int P_SF  = trap_pkg::P_SF,
  parameter int P_TM  = trap_pkg::P_TM,
  parameter int P_TS_L = trap_pkg::P_TS_L,
  parameter int P_VEC = trap_pkg::P_VEC,
  parameter int P_VSX = trap_pkg::P_VSX,
  parameter int P_EE  = trap_pkg::P_EE,
  parameter int P_PR  = trap_pkg::P_PR,
  parameter int P_FP  = trap_pkg::P_FP,
  parameter int P_FE0 = trap_pkg::P_FE0,
  parameter int P_TE_L = trap_pkg::P_TE_L,
  parameter int P_FE1 = trap_pkg::P_FE1,
  parameter int P_UND = trap_pkg::P_UND,
  parameter int P_IR  = trap_pkg::P_IR,
  parameter int P_DR  = trap_pkg::P_DR,
  parameter int P_PMM = trap_pkg::P_PMM,
  parameter int P_RI  = trap_pkg::P_RI,
  parameter int P_LE  = trap_pkg::P_LE
) (
  input  logic [W-1:0] msr_i,
  output logic [W-1:0] msr_o
);
  localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};
  localparam logic [W-1:0] CLR_MASK =
      (ONE << P_IR) | (ONE << P_DR) | (ONE << P_FE0) | (ONE << P_FE1) |
      (ONE << P_EE) | (ONE << P_RI) | (ONE << P_TM)  | (ONE << P_VEC) |
      (ONE << P_VSX)| (ONE << P_PR) | (ONE << P_FP)  | (ONE << P_PMM) |
      (ONE << P_TE_L) | (ONE << (P_TE_L + 1)) | (ONE << P_UND);
  localparam logic [W-1:0] SET_MASK = (ONE << P_SF) | (ONE << P_LE);

  logic [1:0] ts_old;

  always_comb begin
    ts_old = msr_i[P_TS_L +: 2];
    msr_o  = (msr_i & ~CLR_MASK) | SET_MASK;
    if (ts_old == 2'b10) msr_o[P_TS_L +: 2] = 2'b01;
  end
endmodule

// File: rtl/trap_srr1_gen.sv
module trap_srr1_gen #(
  parameter int W      = 64,
  parameter int TT_W   = 5,
  parameter int S_ADR  = trap_pkg::S_ADR,
  parameter int S_TRAP = trap_pkg::S_TRAP,
  parameter int S_PRIV = trap_pkg::S_PRIV,
  parameter int S_ILL  = trap_pkg::S_ILL,
  parameter int S_FP   = trap_pkg::S_FP,
  parameter int S_TMB  = trap_pkg::S_TMB,
  parameter int S_CLR_L = trap_pkg::S_CLR_L,
  parameter int S_CLR_H = trap_pkg::S_CLR_H
) (
  input  logic [W-1:0]    msr_i,
  input  logic [TT_W-1:0] tt_i,
  output logic [W-1:0]    srr1_o
);
  localparam int CLR_N = S_CLR_H - S_CLR_L + 1;

  always_comb begin
    srr1_o = msr_i;
    srr1_o[S_CLR_L +: CLR_N] = '0;
    srr1_o[S_TRAP] = ~|tt_i;
    srr1_o[S_PRIV] = tt_i[1];
    srr1_o[S_FP]   = tt_i[0];
    srr1_o[S_ADR]  = tt_i[3];
    srr1_o[S_ILL]  = tt_i[4];
    srr1_o[S_TMB]  = 1'b0;
  end
endmodule

// File: rtl/trap_entry_stage.sv
module trap_entry_stage #(
  parameter int XLEN   = trap_pkg::XLEN,
  parameter int TT_W   = trap_pkg::TT_W,
  parameter int VIDX_W = trap_pkg::VIDX_W,
  parameter int VSHIFT = 4
) (
  input  logic [XLEN-1:0]   a_i,
  input  logic [XLEN-1:0]   b_i,
  input  logic [4:0]        cond_mask_i,
  input  logic              is32_i,
  input  logic [TT_W-1:0]   trap_type_i,
  input  logic [XLEN-1:0]   msr_i,
  input  logic [XLEN-1:0]   cia_i,
  input  logic [VIDX_W-1:0] vec_idx_i,
  output logic [XLEN-1:0]   msr_o,
  output logic              msr_vld_o,
  output logic [XLEN-1:0]   srr0_o,
  output logic              srr0_vld_o,
  output logic [XLEN-1:0]   srr1_o,
  output logic              srr1_vld_o,
  output logic [XLEN-1:0]   nia_o,
  output logic              nia_vld_o
);
  logic [4:0]      cmp_res;
  logic [XLEN-1:0] msr_new, srr1_new, nia_new;
  logic            take;

  trap_cmp #(.W(XLEN)) u_cmp (
    .a_i(a_i), .b_i(b_i), .is32_i(is32_i), .res_o(cmp_res)
  );

  trap_msr_gen #(.W(XLEN)) u_msr (
    .msr_i(msr_i), .msr_o(msr_new)
  );

  trap_srr1_gen #(.W(XLEN), .TT_W(TT_W)) u_srr1 (
    .msr_i(msr_i), .tt_i(trap_type_i), .srr1_o(srr1_new)
  );

  always_comb begin
    take    = (|trap_type_i) | (|(cmp_res & cond_mask_i));
    nia_new = {{(XLEN-VIDX_W){1'b0}}, vec_idx_i} << VSHIFT;
    msr_vld_o  = take;
    srr0_vld_o = take;
    srr1_vld_o = take;
    nia_vld_o  = take;
    msr_o  = take ? msr_new  : '0;
    srr0_o = take ? cia_i    : '0;
    srr1_o = take ? srr1_new : '0;
    nia_o  = take ? nia_new  : '0;
  end

  always_comb begin
    p_vld_agree_r10: assert (msr_vld_o == srr0_vld_o && srr0_vld_o == srr1_vld_o
                             && srr1_vld_o == nia_vld_o)
      else $error("R10 valid flags disagree");
    if (!msr_vld_o) begin
      p_quiet_r10: assert (msr_o == '0 && srr0_o == '0 && srr1_o == '0 && nia_o == '0)
        else $error("R10 data not zero without trap");
    end
    if (|trap_type_i) begin
      p_forced_r3: assert (msr_vld_o) else $error("R3 forced trap not taken");
    end
    if (msr_vld_o) begin
      p_mode_r4: assert (msr_o[trap_pkg::P_SF] && msr_o[trap_pkg::P_LE] && !msr_o[trap_pkg::P_PR])
        else $error("R4 mode bits wrong");
      if (msr_i[trap_pkg::P_TS_L +: 2] == 2'b10) begin
        p_ts_r5: assert (msr_o[trap_pkg::P_TS_L +: 2] == 2'b01) else $error("R5 ts");
      end
      p_srr0_r6: assert (srr0_o == cia_i) else $error("R6 srr0");
      p_reason_r8: assert (srr1_o[trap_pkg::S_TRAP] == (trap_type_i == '0))
        else $error("R8 reason bit");
      p_align_r9: assert (nia_o[VSHIFT-1:0] == '0) else $error("R9 alignment");
    end
  end
endmodule

// File: tb/trap_entry_stage_tb_top.sv
module trap_entry_stage_tb_top;
  import trap_pkg::*;

  logic clk;
  initial clk = 1'b0;
  always #2 clk = ~clk;

  logic [63:0] a, b, msr, cia;
  logic [4:0]  mask, tt;
  logic        is32;
  logic [11:0] vidx;
  logic [63:0] msr_o, srr0_o, srr1_o, nia_o;
  logic        msr_v, srr0_v, srr1_v, nia_v;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  trap_entry_stage dut_i (
    .a_i(a), .b_i(b), .cond_mask_i(mask), .is32_i(is32), .trap_type_i(tt),
    .msr_i(msr), .cia_i(cia), .vec_idx_i(vidx),
    .msr_o(msr_o), .msr_vld_o(msr_v), .srr0_o(srr0_o), .srr0_vld_o(srr0_v),
    .srr1_o(srr1_o), .srr1_vld_o(srr1_v), .nia_o(nia_o), .nia_vld_o(nia_v)
  );

  function automatic logic [4:0] f_cmp(logic [63:0] x, logic [63:0] y, logic m32);
    longint sx, sy;
    logic [63:0] ux, uy;
    logic [4:0] r;
    if (m32) begin
      sx = longint'($signed(x[31:0]));
      sy = longint'($signed(y[31:0]));
      ux = {32'd0, x[31:0]};
      uy = {32'd0, y[31:0]};
    end else begin
      sx = $signed(x); sy = $signed(y); ux = x; uy = y;
    end
    r[0] = ux > uy;
    r[1] = ux < uy;
    r[2] = ux == uy;
    r[3] = sx > sy;
    r[4] = sx < sy;
    return r;
  endfunction

  function automatic logic f_take(logic [4:0] c, logic [4:0] m, logic [4:0] t);
    return (t != 0) || ((c & m) != 0);
  endfunction

  function automatic logic [63:0] f_msr(logic [63:0] old);
    logic [63:0] r = old;
    int clr[15] = '{P_IR, P_DR, P_FE0, P_FE1, P_EE, P_RI, P_TM, P_VEC, P_VSX,
                    P_PR, P_FP, P_PMM, P_TE_L, P_TE_L + 1, P_UND};
    foreach (clr[i]) r[clr[i]] = 1'b0;
    r[P_SF] = 1'b1;
    r[P_LE] = 1'b1;
    if (old[P_TS_L + 1] && !old[P_TS_L]) begin
      r[P_TS_L + 1] = 1'b0;
      r[P_TS_L] = 1'b1;
    end
    return r;
  endfunction

  function automatic logic [63:0] f_srr1(logic [63:0] old, logic [4:0] t);
    logic [63:0] r = old;
    for (int i = S_CLR_L; i <= S_CLR_H; i++) r[i] = 1'b0;
    r[S_TRAP] = (t == 5'd0);
    r[S_PRIV] = t[1];
    r[S_FP]   = t[0];
    r[S_ADR]  = t[3];
    r[S_ILL]  = t[4];
    r[S_TMB]  = 1'b0;
    return r;
  endfunction

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic apply(logic [63:0] xa, logic [63:0] xb, logic [4:0] xm, logic xs,
                       logic [4:0] xt, logic [63:0] xmsr, logic [63:0] xcia,
                       logic [11:0] xv);
    logic [4:0] c;
    logic tk;
    @(negedge clk);
    a = xa; b = xb; mask = xm; is32 = xs; tt = xt; msr = xmsr; cia = xcia; vidx = xv;
    #1;
    c  = f_cmp(xa, xb, xs);
    tk = f_take(c, xm, xt);
    chk("R3/R10 valid msr",  {63'd0, msr_v},  {63'd0, tk});
    chk("R10 valid srr0", {63'd0, srr0_v}, {63'd0, tk});
    chk("R10 valid srr1", {63'd0, srr1_v}, {63'd0, tk});
    chk("R10 valid nia",  {63'd0, nia_v},  {63'd0, tk});
    chk("R4/R5 msr",  msr_o,  tk ? f_msr(xmsr) : 64'd0);
    chk("R6 srr0",    srr0_o, tk ? xcia : 64'd0);
    chk("R7/R8 srr1", srr1_o, tk ? f_srr1(xmsr, xt) : 64'd0);
    chk("R9 nia",     nia_o,  tk ? ({52'd0, xv} << 4) : 64'd0);
  endtask

  function automatic logic [63:0] r64();
    return {$urandom(), $urandom()};
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    // R10: no mask, no type -> quiet outputs
    apply(64'd5, 64'd5, 5'd0, 1'b0, 5'd0, 64'hFFFF_FFFF_FFFF_FFFF, 64'h1000, 12'h7);
    // R1 equal bit (mask bit 2)
    apply(64'd9, 64'd9, 5'b00100, 1'b0, 5'd0, 64'h0, 64'h2000, 12'h70);
    // R1 unsigned greater only
    apply(64'd9, 64'd3, 5'b00001, 1'b0, 5'd0, 64'h0, 64'h2004, 12'h1);
    // R2 signed vs unsigned disagree: -1 vs 1, signed-less traps
    apply(64'hFFFF_FFFF_FFFF_FFFF, 64'd1, 5'b10000, 1'b0, 5'd0, 64'h0, 64'h8, 12'h2);
    apply(64'hFFFF_FFFF_FFFF_FFFF, 64'd1, 5'b00010, 1'b0, 5'd0, 64'h0, 64'h8, 12'h2);
    // R2 32-bit: low words equal, high differ -> equal traps
    apply(64'h1234_0000_0000_0042, 64'h0000_0000_0000_0042, 5'b00100, 1'b1, 5'd0,
          64'h0, 64'hC, 12'h3);
    apply(64'h1234_0000_0000_0042, 64'h0000_0000_0000_0042, 5'b00100, 1'b0, 5'd0,
          64'h0, 64'hC, 12'h3);
    // R2 32-bit sign boundary: low 0x80000000 is negative in signed view
    apply(64'h0000_0000_8000_0000, 64'd1, 5'b10000, 1'b1, 5'd0, 64'h0, 64'h10, 12'h4);
    apply(64'h0000_0000_8000_0000, 64'd1, 5'b10000, 1'b0, 5'd0, 64'h0, 64'h10, 12'h4);
    // R5 ts 10 -> 01, ts 11 kept
    apply(64'd0, 64'd0, 5'd0, 1'b0, 5'b00001, 64'h0000_0004_0000_0000, 64'h14, 12'hFFF);
    apply(64'd0, 64'd0, 5'd0, 1'b0, 5'b00010, 64'h0000_0006_0000_0000, 64'h14, 12'hFFF);
    // R8 each type bit alone, incl. bit 2 with no reason bit
    for (int k = 0; k < 5; k++)
      apply(64'd1, 64'd2, 5'd0, 1'b0, 5'(1 << k), 64'hFFFF_FFFF_FFFF_FFFF, 64'h18, 12'h5);
    // random mix
    for (int i = 0; i < 3000; i++) begin
      logic [63:0] ra, rb;
      int cls = $urandom_range(0, 3);
      ra = r64(); rb = r64();
      if (cls == 1) rb = ra;
      if (cls == 2) rb = {r64() >> 32, ra[31:0]};
      if (cls == 3) begin
        ra = 64'($urandom_range(0, 4)) | ($urandom_range(0, 1) ? 64'h8000_0000 : 64'h0);
        rb = 64'($urandom_range(0, 4)) | ($urandom_range(0, 1) ? 64'hFFFF_FFFF_8000_0000 : 64'h0);
      end
      apply(ra, rb,
            ($urandom_range(0, 1) ? 5'(1 << $urandom_range(0, 4)) : 5'($urandom())),
            1'($urandom()),
            ($urandom_range(0, 3) == 0 ? 5'($urandom()) : 5'd0),
            r64(), r64(), 12'($urandom()));
    end
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule